// File: doc/BRIEF.md
# SPI Serial SRAM Slave Port

This block is the serial slave front end of a byte-wide memory with a 15-bit address space. An external controller selects it with an active-low chip enable and shifts in an op-code byte, then for memory accesses a two-byte address, then any number of data bytes. The block writes received bytes into an internal RAM, or streams stored bytes back on the serial output. The address steps forward after every byte, and it wraps either inside a 64-byte page or across the whole address space, according to a mode bit in a small status register.

The port inputs are resynchronised to the block clock and their edges are detected there, so the serial clock must be several times slower than the block clock. The serial output comes as a data bit plus an output-enable, so the pad ring can build the tri-state buffer. A write-enable latch, write-protect ranges and a hold input guard the contents and let a shared controller pause a transfer. The internal storage depth is a parameter: the address counter always keeps 15 bits, and the RAM decodes only the low `MEM_AW` of them.

Top module: `spi_sram_port`

## Requirements
- R1: `spi_so_oe` is low during reset and whenever chip enable (`spi_cs_n`) is high.
- R2: Both serial modes with clock polarity equal to phase (idle low, or idle high) work. SI is sampled on rising SCK edges and SO changes only after falling SCK edges. Every byte travels most significant bit first.
- R3: Op-codes are 0x03 (read) and 0x02 (write), each followed by an address high byte and an address low byte. The top bit of the high byte is ignored.
- R4: After each data byte of a read or write burst, the address moves to the next location, so a burst touches consecutive bytes.
- R5: With status bit 5 clear (the reset value), the address wraps from offset 63 back to offset 0 of the same 64-byte page.
- R6: With status bit 5 set, the address runs across page boundaries and wraps from 0x7FFF to 0x0000.
- R7: Op-code 0x06 sets a write-enable latch and 0x04 clears it. Data writes and status writes are ignored while the latch is clear. The latch clears when chip enable rises after a write (0x02) or status-write (0x01) op-code.
- R8: Op-code 0x05 returns the status byte, repeated for as long as clocks continue: bit 5 rollover mode, bits 3:2 protect code, bit 1 write-enable latch, all other bits zero. Reset value 0x00. Op-code 0x01 followed by a byte loads bits 5, 3 and 2 when the latch is set.
- R9: The protect code inhibits data writes: 00 none, 01 addresses 0x6000–0x7FFF, 10 addresses 0x4000–0x7FFF, 11 every address.
- R10: After an op-code other than 0x01–0x06, further bytes are ignored and `spi_so_oe` stays low until chip enable rises. The next selection decodes normally.
- R11: While `spi_hold_n` is low, SCK edges are ignored and `spi_so_oe` is low. The transfer resumes at the same bit when hold is released.
- R12: The RAM decodes address bits `MEM_AW-1:0` (default 10), so addresses that differ only in higher bits name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip enable, active low |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for the serial data out pad |

## Verification
The bench writes bursts that start two bytes before a page end and one byte before the top of the address space. A design that wraps the wrong way puts the last byte into the next page, or fails to reach address zero, and read-back shows the error. Writes are tried with the latch clear, after a status write, after 0x04, and into each protect range. A latch that does not clear at the end of a sequence, or a protect decode that is off by one range, lets a stored value be overwritten. An invalid op-code followed by what looks like a valid write must leave memory unchanged and SO undriven. A hold asserted in the middle of a read byte must not shift a bit or let SO drive, or the returned byte comes back rotated.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 15;
    localparam int PAGE_AW   = 6;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int BP_W      = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_WR_STATUS = 8'h01;
    localparam byte_t OP_WRITE     = 8'h02;
    localparam byte_t OP_READ      = 8'h03;
    localparam byte_t OP_WE_CLEAR  = 8'h04;
    localparam byte_t OP_RD_STATUS = 8'h05;
    localparam byte_t OP_WE_SET    = 8'h06;

    localparam int ST_WEL_BIT  = 1;
    localparam int ST_BP_LO    = 2;
    localparam int ST_ROLL_BIT = 5;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA,
        PH_STAT_IN,
        PH_STAT_OUT,
        PH_IDLE,
        PH_PARKED
    } phase_e;

    typedef struct packed {
        logic            roll_full;
        logic [BP_W-1:0] bp;
    } cfg_t;

    // Step the address, wrapping inside a page unless full-range mode is on.
    function automatic addr_t next_addr(input addr_t a, input logic full);
        addr_t inc;
        inc = a + addr_t'(1);
        if (full) return inc;
        return {a[ADDR_W-1:PAGE_AW], inc[PAGE_AW-1:0]};
    endfunction

    // Upper quarter, upper half or everything, depending on the code.
    function automatic logic is_protected(input addr_t a, input logic [BP_W-1:0] bp);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1 -: 2] == 2'b11;
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic byte_t pack_status(input cfg_t c, input logic wel);
        byte_t s;
        s = '0;
        s[ST_ROLL_BIT]         = c.roll_full;
        s[ST_BP_LO +: BP_W]    = c.bp;
        s[ST_WEL_BIT]          = wel;
        return s;
    endfunction

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
    parameter int MEM_AW = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) ram[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= ram[addr];
    end

endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
    import spi_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n_s,
    input  logic                 sck_s,
    input  logic                 si_s,
    input  logic                 hold_n_s,
    input  byte_t                rd_byte,
    output logic                 cs_act,
    output logic                 hold_ok,
    output logic                 fall_act,
    output logic                 at_byte_start,
    output logic                 out_phase,
    output byte_t                load_byte,
    output logic                 mem_we,
    output addr_t                mem_addr,
    output byte_t                mem_wdata,
    output phase_e               phase,
    output logic [BIT_CNT_W-1:0] bitcnt,
    output logic                 wel,
    output logic                 wr_seq,
    output cfg_t                 cfg
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic                sck_q;
    logic                rise_act;
    logic                byte_done;
    logic                is_rd;
    logic [BYTE_W-2:0]   shin;
    byte_t               byte_in;
    addr_t               addr;

    assign cs_act        = !cs_n_s;
    assign hold_ok       = hold_n_s;
    assign rise_act      = cs_act && hold_ok &&  sck_s && !sck_q;
    assign fall_act      = cs_act && hold_ok && !sck_s &&  sck_q;
    assign byte_in       = {shin, si_s};
    assign byte_done     = rise_act && (bitcnt == LAST_BIT);
    assign at_byte_start = (bitcnt == '0);

    assign mem_addr  = addr;
    assign mem_wdata = byte_in;
    assign mem_we    = byte_done && (phase == PH_DATA) && !is_rd && wel
                       && !is_protected(addr, cfg.bp);

    assign out_phase = ((phase == PH_DATA) && is_rd) || (phase == PH_STAT_OUT);
    assign load_byte = (phase == PH_STAT_OUT) ? pack_status(cfg, wel) : rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            bitcnt <= '0;
            shin   <= '0;
            phase  <= PH_CMD;
            addr   <= '0;
            is_rd  <= 1'b0;
            wel    <= 1'b0;
            wr_seq <= 1'b0;
            cfg    <= '0;
        end else begin
            sck_q <= sck_s;
            if (!cs_act) begin
                bitcnt <= '0;
                phase  <= PH_CMD;
                is_rd  <= 1'b0;
                wr_seq <= 1'b0;
                if (wr_seq) wel <= 1'b0;
            end else if (rise_act) begin
                shin   <= byte_in[BYTE_W-2:0];
                bitcnt <= bitcnt + BIT_CNT_W'(1);
                if (bitcnt == LAST_BIT) begin
                    case (phase)
                        PH_CMD: begin
                            case (byte_in)
                                OP_WE_SET:    begin wel <= 1'b1; phase <= PH_IDLE; end
                                OP_WE_CLEAR:  begin wel <= 1'b0; phase <= PH_IDLE; end
                                OP_RD_STATUS: phase <= PH_STAT_OUT;
                                OP_WR_STATUS: begin wr_seq <= 1'b1; phase <= PH_STAT_IN; end
                                OP_READ:      begin is_rd <= 1'b1; phase <= PH_ADDR_HI; end
                                OP_WRITE:     begin
                                    is_rd  <= 1'b0;
                                    wr_seq <= 1'b1;
                                    phase  <= PH_ADDR_HI;
                                end
                                default:      phase <= PH_PARKED;
                            endcase
                        end
                        PH_ADDR_HI: begin
                            addr[ADDR_W-1:BYTE_W] <= byte_in[ADDR_W-BYTE_W-1:0];
                            phase <= PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            addr[BYTE_W-1:0] <= byte_in;
                            phase <= PH_DATA;
                        end
                        PH_DATA: addr <= next_addr(addr, cfg.roll_full);
                        PH_STAT_IN: begin
                            if (wel) begin
                                cfg.roll_full <= byte_in[ST_ROLL_BIT];
                                cfg.bp        <= byte_in[ST_BP_LO +: BP_W];
                            end
                            phase <= PH_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spi_sram_tx.sv
module spi_sram_tx
    import spi_sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_act,
    input  logic  hold_ok,
    input  logic  fall_act,
    input  logic  at_byte_start,
    input  logic  out_phase,
    input  byte_t load_byte,
    output logic  so,
    output logic  so_oe
);

    byte_t shreg;
    logic  valid;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            shreg <= '0;
            valid <= 1'b0;
        end else if (fall_act) begin
            if (at_byte_start) begin
                shreg <= load_byte;
                valid <= out_phase;
            end else begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign so_oe = valid && out_phase && hold_ok;
    assign so    = shreg[BYTE_W-1] && so_oe;

endmodule

// File: rtl/spi_sram_port.sv
module spi_sram_port
    import spi_sram_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    input  logic spi_hold_n,
    output logic spi_so,
    output logic spi_so_oe
);

    localparam int N_IN = 4;

    logic [N_IN-1:0]      pins_s;
    logic                 cs_act;
    logic                 hold_ok;
    logic                 fall_act;
    logic                 at_byte_start;
    logic                 out_phase;
    byte_t                load_byte;
    logic                 mem_we;
    addr_t                mem_addr;
    byte_t                mem_wdata;
    byte_t                rd_byte;
    phase_e               phase;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic                 wel;
    logic                 wr_seq;
    cfg_t                 cfg;
    logic                 so;
    logic                 so_oe;

    spi_sram_sync #(
        .WIDTH   (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_si, spi_hold_n}),
        .q   (pins_s)
    );

    spi_sram_ctrl i_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cs_n_s        (pins_s[3]),
        .sck_s         (pins_s[2]),
        .si_s          (pins_s[1]),
        .hold_n_s      (pins_s[0]),
        .rd_byte       (rd_byte),
        .cs_act        (cs_act),
        .hold_ok       (hold_ok),
        .fall_act      (fall_act),
        .at_byte_start (at_byte_start),
        .out_phase     (out_phase),
        .load_byte     (load_byte),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .phase         (phase),
        .bitcnt        (bitcnt),
        .wel           (wel),
        .wr_seq        (wr_seq),
        .cfg           (cfg)
    );

    spi_sram_mem #(
        .MEM_AW (MEM_AW),
        .DATA_W (BYTE_W)
    ) i_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr[MEM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (rd_byte)
    );

    spi_sram_tx i_tx (
        .clk           (clk),
        .rst           (rst),
        .cs_act        (cs_act),
        .hold_ok       (hold_ok),
        .fall_act      (fall_act),
        .at_byte_start (at_byte_start),
        .out_phase     (out_phase),
        .load_byte     (load_byte),
        .so            (so),
        .so_oe         (so_oe)
    );

    assign spi_so    = so;
    assign spi_so_oe = so_oe;

endmodule

// File: rtl/spi_sram_port_chk.sv
module spi_sram_port_chk
    import spi_sram_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_act,
    input logic                 hold_ok,
    input logic                 fall_act,
    input phase_e               phase,
    input logic [BIT_CNT_W-1:0] bitcnt,
    input logic                 wel,
    input logic                 wr_seq,
    input cfg_t                 cfg,
    input addr_t                mem_addr,
    input logic                 mem_we,
    input logic                 so,
    input logic                 so_oe
);

    // R1
    cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && $past(!cs_act)) |-> !so_oe);

    // R2
    so_moves_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && !$past(fall_act)) |-> $stable(so));

    // R4
    addr_steps_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_addr != $past(mem_addr)));

    // R5
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_DATA) && $past(phase == PH_DATA) && !cfg.roll_full)
        |-> (mem_addr[ADDR_W-1:PAGE_AW] == $past(mem_addr[ADDR_W-1:PAGE_AW])));

    // R7
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && $past(cs_act) && $past(wr_seq)) |=> !wel);

    // R9
    full_protect_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cfg.bp != 2'b11));

    // R10
    parked_stays_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_PARKED) && cs_act) |=> (phase == PH_PARKED));

    // R10
    parked_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PARKED) |-> (!so_oe && !mem_we));

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !hold_ok) |=> $stable(bitcnt));

endmodule

bind spi_sram_port spi_sram_port_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .hold_ok  (hold_ok),
    .fall_act (fall_act),
    .phase    (phase),
    .bitcnt   (bitcnt),
    .wel      (wel),
    .wr_seq   (wr_seq),
    .cfg      (cfg),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .so       (so),
    .so_oe    (so_oe)
);

// File: tb/test_spi_sram_port.sv
module test_spi_sram_port;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_si = 1'b0;
    logic spi_hold_n = 1'b1;
    logic spi_so;
    logic spi_so_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mode3 = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #10 clk = ~clk;

    spi_sram_port i_spi_sram_port (
        .clk        (clk),
        .rst        (rst),
        .spi_cs_n   (spi_cs_n),
        .spi_sck    (spi_sck),
        .spi_si     (spi_si),
        .spi_hold_n (spi_hold_n),
        .spi_so     (spi_so),
        .spi_so_oe  (spi_so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor: pairs each captured byte with the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0 && exp_q.size() != 0) begin
                logic [7:0] got;
                logic [7:0] want;
                string      t;
                got  = obs_q.pop_front();
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(got === want, t, got, want);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        report();
    end

    task automatic hold_pause();
        spi_hold_n = 1'b0;
        tick(H);
        for (int k = 0; k < 2; k++) begin
            spi_sck = 1'b0;
            tick(H);
            // R11: SO undriven while paused
            check(!spi_so_oe, "R11", {7'b0, spi_so_oe}, 8'h00);
            spi_sck = 1'b1;
            tick(H);
        end
        spi_hold_n = 1'b1;
        tick(H);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit any_oe, input int hold_at);
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            spi_sck = 1'b0;
            spi_si  = tx[i];
            tick(H);
            rx[i] = spi_so_oe ? spi_so : 1'bx;
            if (spi_so_oe) any_oe = 1'b1;
            spi_sck = 1'b1;
            tick(H);
            if (i == hold_at) hold_pause();
        end
    endtask

    task automatic cs_begin();
        spi_sck = mode3;
        tick(H);
        spi_cs_n = 1'b0;
        tick(H);
    endtask

    task automatic cs_end();
        if (!mode3) spi_sck = 1'b0;
        tick(H);
        spi_cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic send1(input logic [7:0] op);
        logic [7:0] rx;
        bit oe;
        cs_begin();
        xbyte(op, rx, oe, -1);
        cs_end();
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] rx;
        bit oe;
        cs_begin();
        xbyte(8'h01, rx, oe, -1);
        xbyte(v, rx, oe, -1);
        cs_end();
    endtask

    task automatic rd_status(input int n, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        bit oe;
        cs_begin();
        xbyte(8'h05, rx, oe, -1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            xbyte(8'h00, rx, oe, -1);
            obs_q.push_back(rx);
        end
        cs_end();
    endtask

    task automatic wr_burst(input logic [15:0] a, input int n, input logic [7:0] d[4]);
        logic [7:0] rx;
        bit oe;
        cs_begin();
        xbyte(8'h02, rx, oe, -1);
        xbyte(a[15:8], rx, oe, -1);
        xbyte(a[7:0], rx, oe, -1);
        for (int k = 0; k < n; k++) xbyte(d[k], rx, oe, -1);
        cs_end();
    endtask

    task automatic rd_burst(input logic [15:0] a, input int n, input logic [7:0] e[4],
                            input string tag, input int hold_at);
        logic [7:0] rx;
        bit oe;
        cs_begin();
        xbyte(8'h03, rx, oe, -1);
        xbyte(a[15:8], rx, oe, -1);
        xbyte(a[7:0], rx, oe, -1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(e[k]);
            tag_q.push_back(tag);
            xbyte(8'h00, rx, oe, (k == 0) ? hold_at : -1);
            obs_q.push_back(rx);
        end
        cs_end();
    endtask

    task automatic rd1(input logic [15:0] a, input logic [7:0] e, input string tag);
        rd_burst(a, 1, '{e, 8'h00, 8'h00, 8'h00}, tag, -1);
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] d);
        wr_burst(a, 1, '{d, 8'h00, 8'h00, 8'h00});
    endtask

    initial begin
        logic [7:0] rx;
        bit oe;
        bit seen_oe;

        tick(4);
        // R1: output undriven in reset
        check(!spi_so_oe, "R1", {7'b0, spi_so_oe}, 8'h00);
        rst = 1'b0;
        tick(4);
        // R1: output undriven with chip enable high after reset
        check(!spi_so_oe, "R1", {7'b0, spi_so_oe}, 8'h00);

        rd_status(1, 8'h00, "R8 reset status");

        // R7: latch set, write lands, latch clears, unlatched write ignored
        send1(8'h06);
        rd_status(1, 8'h02, "R7 latch visible");
        wr1(16'h0010, 8'h11);
        rd_status(1, 8'h00, "R7 latch cleared by write end");
        wr1(16'h0010, 8'hAA);
        rd1(16'h0010, 8'h11, "R7 write without latch");

        // R3/R4: burst write and read back in mode 0
        send1(8'h06);
        wr_burst(16'h0100, 4, '{8'h5A, 8'hC3, 8'h01, 8'hFE});
        rd_burst(16'h0100, 4, '{8'h5A, 8'hC3, 8'h01, 8'hFE}, "R4 burst", -1);

        // R2: idle-high clock mode for read and write
        mode3 = 1'b1;
        rd_burst(16'h0101, 2, '{8'hC3, 8'h01, 8'h00, 8'h00}, "R2 mode3 read", -1);
        send1(8'h06);
        wr1(16'h0200, 8'h81);
        mode3 = 1'b0;
        rd1(16'h0200, 8'h81, "R2 mode3 write");

        // R5: page wrap for write and read
        send1(8'h06);
        wr_burst(16'h013E, 3, '{8'hA1, 8'hA2, 8'hA3, 8'h00});
        rd_burst(16'h013E, 3, '{8'hA1, 8'hA2, 8'hA3, 8'h00}, "R5 page wrap read", -1);
        rd1(16'h0100, 8'hA3, "R5 page wrap write");
        // R3: top address bit ignored
        rd1(16'h8101, 8'hC3, "R3 top bit ignored");

        // R6: full-range wrap
        send1(8'h06);
        wr_status(8'h20);
        rd_status(2, 8'h20, "R8 status repeat");
        send1(8'h06);
        wr_burst(16'h7FFF, 2, '{8'h3C, 8'h4D, 8'h00, 8'h00});
        rd_burst(16'h7FFF, 2, '{8'h3C, 8'h4D, 8'h00, 8'h00}, "R6 top wrap read", -1);
        rd1(16'h0000, 8'h4D, "R6 top wrap write");
        rd1(16'h4000, 8'h4D, "R12 alias");

        // R9: protect ranges
        send1(8'h06);
        wr_status(8'h24);
        rd_status(1, 8'h24, "R8 status write");
        send1(8'h06);
        wr1(16'h6000, 8'h99);
        rd1(16'h6000, 8'h4D, "R9 quarter blocked");
        send1(8'h06);
        wr1(16'h5FFF, 8'h77);
        rd1(16'h5FFF, 8'h77, "R9 quarter edge open");
        send1(8'h06);
        wr_status(8'h28);
        send1(8'h06);
        wr1(16'h4010, 8'h12);
        rd1(16'h0010, 8'h11, "R9 half blocked");
        send1(8'h06);
        wr1(16'h3FFF, 8'h21);
        rd1(16'h3FFF, 8'h21, "R9 half edge open");
        send1(8'h06);
        wr_status(8'h2C);
        send1(8'h06);
        wr1(16'h0010, 8'hEE);
        rd1(16'h0010, 8'h11, "R9 all blocked");
        send1(8'h06);
        wr_status(8'h00);
        rd_status(1, 8'h00, "R8 status cleared");

        // R7: explicit latch clear
        send1(8'h06);
        send1(8'h04);
        wr1(16'h0010, 8'h55);
        rd1(16'h0010, 8'h11, "R7 cleared by 0x04");

        // R10: unknown op-code parks the port
        send1(8'h06);
        cs_begin();
        seen_oe = 1'b0;
        xbyte(8'hA5, rx, oe, -1);
        seen_oe |= oe;
        xbyte(8'h02, rx, oe, -1);
        seen_oe |= oe;
        xbyte(8'h00, rx, oe, -1);
        seen_oe |= oe;
        xbyte(8'h10, rx, oe, -1);
        seen_oe |= oe;
        xbyte(8'h99, rx, oe, -1);
        seen_oe |= oe;
        cs_end();
        check(!seen_oe, "R10", {7'b0, seen_oe}, 8'h00);
        rd1(16'h0010, 8'h11, "R10 no write and recovery");
        send1(8'h04);

        // R11: pause in the middle of a read byte
        send1(8'h06);
        wr1(16'h0030, 8'hB6);
        rd_burst(16'h0030, 1, '{8'hB6, 8'h00, 8'h00, 8'h00}, "R11 resume", 4);

        tick(4 * H);
        check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
        report();
    end

endmodule